// File: doc/BRIEF.md
# SD Card Clock Prescaler and Divisor Calculator

This block sits between a host controller's register front end and a clock generator that is built from two stages: a power-of-two prescaler followed by a small linear divisor. Software writes a standard 16-bit clock-control halfword that carries a divider request. The block works out the card clock frequency that the request stands for and searches for the prescaler and divisor pair that first brings the generated clock at or below that frequency. It then stores that pair in a native 16-bit clock register, which is brought out on a port.

A variant input picks one of two request conventions. In the first, an 8-bit divider selects a power-of-two division of the base clock. In the second, a 10-bit divider selects an even division of the base clock. The search takes several cycles. It uses only multiplies and compares, plus a shift-subtract divider that the second convention needs. A busy output covers the whole search. Reading back the clock-control halfword returns the divider bits that were last written, merged with fixed and live status bits.

Top module: `sdclk_divcalc`

## Requirements
- R1: With `variant_b` low, the divider N is `wr_data[15:8]`. The requested frequency f is `base_hz` shifted right by the 1-based position of the lowest set bit of N, or by 0 when N is zero.
- R2: With `variant_b` high, the divider N is the 10-bit value {`wr_data[7:6]`, `wr_data[15:8]`}. The requested frequency f is floor(`base_hz` / (2·N)), or `base_hz` itself when N is zero.
- R3: The prescaler p is the first power of two, counting up from 2, for which f ≥ floor(`base_hz` / (16·p)). The search stops at 2^8 if no smaller value qualifies.
- R4: Given p, the divisor d is the first integer, counting up from 1, for which f ≥ floor(`base_hz` / (p·d)). The search stops at 16 if no smaller value qualifies.
- R5: When a search finishes, `native_reg` bits 15:8 take p/2 and bits 7:4 take d−1. Bit 0 is set and bits 3:1 keep their old values. `native_reg` resets to 0x0008.
- R6: A write with bit 2 (card clock enable) clear and `variant_b` low clears `native_reg` bit 3 on the edge that takes it. It leaves all other bits unchanged and does not raise `busy`.
- R7: A write with bit 2 clear and `variant_b` high leaves `native_reg` unchanged and does not raise `busy`.
- R8: Every write that is taken stores its bits 15:6. From the second edge after the write, `rd_data` returns those bits with bit 0 and bit 2 set, bit 1 equal to `clk_stable` at the previous edge, and bits 5:3 zero.
- R9: A write with bit 2 set raises `busy` on the edge that takes it, and `busy` falls on the edge that updates `native_reg`. A write is taken only on an edge where `busy` is low, so a held write waits. While idle with no write, `native_reg` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_b | input | 1 | Selects the 10-bit even-divider convention when high |
| base_hz | input | 32 | Base clock frequency in Hz |
| wr_en | input | 1 | Clock-control halfword write request |
| wr_data | input | 16 | Clock-control halfword being written |
| clk_stable | input | 1 | Internal clock stable flag from present state |
| busy | output | 1 | Search in progress; writes are not taken |
| native_reg | output | 16 | Native prescaler/divisor clock register |
| rd_data | output | 16 | Clock-control halfword readback |

## Verification
The hardest case to reach is a write that arrives while a search is still running. It must wait, neither corrupting the search nor being lost. The bench holds a second write on the bus right after a first enabled write is taken. It samples `native_reg` on the cycle `busy` falls, to confirm that the first result landed alone, and then confirms that the second result follows. Directed writes cover the extremes of the divider fields in both conventions and a base clock small enough to collapse f to zero. Seeded random writes cover the rest of the request space.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  typedef enum logic [1:0] {SR_IDLE, SR_PRE, SR_DIV} srch_state_e;
  localparam logic [15:0] FREQ_MASK   = 16'hFFC0;
  localparam logic [15:0] RD_FIXED    = 16'h0005;
  localparam int unsigned CARD_EN_BIT = 2;
  localparam int unsigned NAT_CARD_BIT = 3;
endpackage

// File: rtl/sdclk_udiv.sv
module sdclk_udiv #(
  parameter int unsigned NUM_W = 32,
  parameter int unsigned DEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W:0]   rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [NUM_W:0]   rem_sh, den_ext;
  logic             fits;

  always_comb begin
    rem_sh  = {rem_q[NUM_W-1:0], quo_q[NUM_W-1]};
    den_ext = {{(NUM_W + 1 - DEN_W){1'b0}}, den_q};
    fits    = (rem_sh >= den_ext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= num;
        den_q <= den;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? (rem_sh - den_ext) : rem_sh;
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/sdclk_search.sv
module sdclk_search
  import sdclk_pkg::*;
#(
  parameter int unsigned BASE_W = 32,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BASE_W-1:0] freq,
  input  logic [BASE_W-1:0] base,
  output logic              done,
  output logic [PRE_W-1:0]  pre_code,
  output logic [DIV_W-1:0]  div_code
);
  localparam int unsigned P_W    = PRE_W + 1;
  localparam int unsigned D_W    = DIV_W + 1;
  localparam int unsigned PROD_W = BASE_W + PRE_W + DIV_W + 3;
  localparam logic [P_W-1:0] P_MAX = {1'b1, {PRE_W{1'b0}}};
  localparam logic [D_W-1:0] D_MAX = {1'b1, {DIV_W{1'b0}}};

  srch_state_e       st_q;
  logic [BASE_W-1:0] f_q, base_q;
  logic [P_W-1:0]    p_q;
  logic [D_W-1:0]    d_q;
  logic [PRE_W-1:0]  pre_q;
  logic [DIV_W-1:0]  div_q;
  logic              done_q;
  logic [PROD_W-1:0] f1, lim, pre_prod, div_prod;
  logic [D_W-1:0]    d_m1;

  // "f < floor(base/y)" is rewritten as "(f+1)*y <= base"
  always_comb begin
    f1       = PROD_W'(f_q) + PROD_W'(1);
    lim      = PROD_W'(base_q);
    pre_prod = (f1 * PROD_W'(p_q)) << DIV_W;
    div_prod = f1 * PROD_W'(p_q) * PROD_W'(d_q);
    d_m1     = d_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SR_IDLE;
      f_q    <= '0;
      base_q <= '0;
      p_q    <= P_W'(2);
      d_q    <= D_W'(1);
      pre_q  <= '0;
      div_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SR_IDLE: if (start) begin
          f_q    <= freq;
          base_q <= base;
          p_q    <= P_W'(2);
          d_q    <= D_W'(1);
          st_q   <= SR_PRE;
        end
        SR_PRE: begin
          if (p_q != P_MAX && pre_prod <= lim) p_q <= p_q << 1;
          else                                 st_q <= SR_DIV;
        end
        SR_DIV: begin
          if (d_q != D_MAX && div_prod <= lim) d_q <= d_q + 1'b1;
          else begin
            pre_q  <= p_q[PRE_W:1];
            div_q  <= d_m1[DIV_W-1:0];
            done_q <= 1'b1;
            st_q   <= SR_IDLE;
          end
        end
        default: st_q <= SR_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign pre_code = pre_q;
  assign div_code = div_q;
endmodule

// File: rtl/sdclk_divcalc.sv
module sdclk_divcalc
  import sdclk_pkg::*;
#(
  parameter int unsigned BASE_W     = 32,
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned DIV_W      = 4,
  parameter int unsigned NATIVE_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              variant_b,
  input  logic [BASE_W-1:0] base_hz,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              clk_stable,
  output logic              busy,
  output logic [PRE_W+DIV_W+3:0] native_reg,
  output logic [15:0]       rd_data
);
  localparam int unsigned NAT_W = PRE_W + DIV_W + 4;
  localparam int unsigned NB_W  = 10;

  logic              busy_q;
  logic [NAT_W-1:0]  nat_q;
  logic [15:0]       cache_q, rd_q;
  logic [BASE_W-1:0] base_q;

  logic              accept, card_en, use_div;
  logic [7:0]        n_a;
  logic [NB_W-1:0]   n_b;
  logic [3:0]        sh_a;
  logic [BASE_W-1:0] freq_a, srch_freq, srch_base, quo;
  logic              div_start, div_done, srch_start, srch_done;
  logic [PRE_W-1:0]  pre_code;
  logic [DIV_W-1:0]  div_code;

  always_comb begin
    accept  = wr_en && !busy_q;
    card_en = wr_data[CARD_EN_BIT];
    n_a     = wr_data[15:8];
    n_b     = {wr_data[7:6], wr_data[15:8]};
    sh_a    = '0;
    for (int i = 7; i >= 0; i--) begin
      if (n_a[i]) sh_a = 4'(i + 1);
    end
    freq_a     = base_hz >> sh_a;
    use_div    = variant_b && (n_b != '0);
    div_start  = accept && card_en && use_div;
    srch_start = (accept && card_en && !use_div) || div_done;
    srch_freq  = div_done ? quo : (variant_b ? base_hz : freq_a);
    srch_base  = div_done ? base_q : base_hz;
  end

  sdclk_udiv #(.NUM_W(BASE_W), .DEN_W(NB_W + 1)) u_udiv (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (base_hz),
    .den   ({n_b, 1'b0}),
    .done  (div_done),
    .quo   (quo)
  );

  sdclk_search #(.BASE_W(BASE_W), .PRE_W(PRE_W), .DIV_W(DIV_W)) u_search (
    .clk      (clk),
    .rst      (rst),
    .start    (srch_start),
    .freq     (srch_freq),
    .base     (srch_base),
    .done     (srch_done),
    .pre_code (pre_code),
    .div_code (div_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      nat_q   <= NAT_W'(NATIVE_RST);
      cache_q <= '0;
      base_q  <= '0;
    end else begin
      if (accept) begin
        cache_q <= wr_data & FREQ_MASK;
        base_q  <= base_hz;
        if (card_en)         busy_q <= 1'b1;
        else if (!variant_b) nat_q[NAT_CARD_BIT] <= 1'b0;
      end
      if (srch_done) begin
        busy_q <= 1'b0;
        nat_q  <= {pre_code, div_code, nat_q[3:1], 1'b1};
      end
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= cache_q | RD_FIXED | {14'd0, clk_stable, 1'b0};
  end

  assign busy       = busy_q;
  assign native_reg = nat_q;
  assign rd_data    = rd_q;
endmodule

// File: rtl/sdclk_divcalc_chk.sv
module sdclk_divcalc_chk (
  input logic        clk,
  input logic        rst,
  input logic        variant_b,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        clk_stable,
  input logic        busy,
  input logic [15:0] native_reg,
  input logic [15:0] rd_data
);
  a_r5_enable_after_search: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> native_reg[0]);
  a_r5_prescaler_pow2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(native_reg[15:8]));
  a_r6_card_clock_off: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && !wr_data[2] && !variant_b) |=> (!native_reg[3] && !busy));
  a_r7_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && !wr_data[2] && variant_b) |=> ($stable(native_reg) && !busy));
  a_r8_fixed_status: assert property (@(posedge clk) disable iff (rst)
    rd_data[0] && rd_data[2] && (rd_data[5:3] == 3'b000));
  a_r8_stable_bit: assert property (@(posedge clk) disable iff (rst)
    rd_data[1] == $past(clk_stable));
  a_r9_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_data[2]) |=> busy);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wr_en) |=> $stable(native_reg));
endmodule

bind sdclk_divcalc sdclk_divcalc_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .variant_b  (variant_b),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .clk_stable (clk_stable),
  .busy       (busy),
  .native_reg (native_reg),
  .rd_data    (rd_data)
);

// File: tb/sdclk_divcalc_bench.sv
module sdclk_divcalc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        variant_b = 1'b0;
  logic [31:0] base_hz = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        clk_stable = 1'b0;
  logic        busy;
  logic [15:0] native_reg, rd_data;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] nat_exp;

  always #2 clk = ~clk;

  sdclk_divcalc u_sdclk_divcalc (
    .clk(clk), .rst(rst), .variant_b(variant_b), .base_hz(base_hz),
    .wr_en(wr_en), .wr_data(wr_data), .clk_stable(clk_stable),
    .busy(busy), .native_reg(native_reg), .rd_data(rd_data)
  );

  function automatic logic [15:0] model(input logic vb, input logic [31:0] b,
                                        input logic [15:0] w, input logic [15:0] prev);
    longint f, p, d, nb;
    int sh;
    sh = 0;
    for (int i = 7; i >= 0; i--) if (w[8+i]) sh = i + 1;
    nb = longint'({w[7:6], w[15:8]});
    if (!vb)          f = longint'(b) >> sh;
    else if (nb == 0) f = longint'(b);
    else              f = longint'(b) / (2 * nb);
    p = 2;
    while (p != 256 && (f + 1) * p * 16 <= longint'(b)) p = p * 2;
    d = 1;
    while (d != 16 && (f + 1) * p * d <= longint'(b)) d = d + 1;
    return {8'(p / 2), 4'(d - 1), prev[3:1], 1'b1};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic vb, input logic [31:0] b, input logic [15:0] w);
    @(negedge clk);
    variant_b = vb; base_hz = b; wr_data = w; wr_en = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_search(input string tag, input logic vb, input logic [31:0] b,
                            input logic [15:0] w);
    logic [15:0] e;
    e = model(vb, b, w, nat_exp);
    do_write(vb, b, w);
    wait_idle();
    nat_exp = e;
    check(tag, native_reg, nat_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] e1, w1, w2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    nat_exp = 16'h0008;
    check("R5 reset native", native_reg, 16'h0008);
    check("R9 reset busy", {15'd0, busy}, 16'd0);
    check("R8 reset readback", rd_data, 16'h0005);

    // R7: variant B, card enable clear
    clk_stable = 1'b1;
    do_write(1'b1, 32'd50_000_000, 16'h12C0);
    check("R7 native unchanged", native_reg, nat_exp);
    check("R7 no busy", {15'd0, busy}, 16'd0);
    @(negedge clk);
    check("R8 cache after ignored write", rd_data, 16'h12C7);

    // R6: variant A, card enable clear
    do_write(1'b0, 32'd50_000_000, 16'h0400);
    nat_exp = 16'h0000;
    check("R6 card clock bit cleared", native_reg, nat_exp);
    check("R6 no busy", {15'd0, busy}, 16'd0);

    // R1/R3/R4: divider zero -> f = base
    run_search("R1 N=0 variant A", 1'b0, 32'd50_000_000, 16'h0004);
    check("R5 base request encoding", native_reg, 16'h0101);
    // R1/R3/R4: f collapses to zero
    run_search("R4 small base f=0", 1'b0, 32'd100, 16'h8004);
    check("R3 small base encoding", native_reg, 16'h04C1);
    run_search("R1 N=0x80 variant A", 1'b0, 32'd200_000_000, 16'h8004);
    // R2: extremes of 10-bit divider
    run_search("R2 N=1023 variant B", 1'b1, 32'hFFFF_FFFF, 16'hFFC4);
    run_search("R2 N=0 variant B", 1'b1, 32'd198_000_000, 16'h0004);
    run_search("R2 N=1 variant B", 1'b1, 32'd198_000_000, 16'h0104);

    // R9: enabled write raises busy; held write waits
    w1 = 16'h0104; w2 = 16'h40C4;
    e1 = model(1'b0, 32'd96_000_000, w1, nat_exp);
    do_write(1'b0, 32'd96_000_000, w1);
    check("R9 busy after enabled write", {15'd0, busy}, 16'd1);
    wr_data = w2; variant_b = 1'b1; wr_en = 1'b1;
    while (busy) @(negedge clk);
    check("R9 first result before held write", native_reg, e1);
    nat_exp = e1;
    @(negedge clk);
    wr_en = 1'b0;
    wait_idle();
    nat_exp = model(1'b1, 32'd96_000_000, w2, e1);
    check("R9 held write result", native_reg, nat_exp);

    // random mix: R1..R5, R8
    for (int k = 0; k < 80; k++) begin
      logic vb;
      logic [31:0] b;
      logic [15:0] w;
      vb = 1'($urandom);
      b  = $urandom >> ($urandom % 24);
      w  = 16'($urandom) & 16'hFFC4 | 16'h0004;
      clk_stable = 1'($urandom);
      run_search(vb ? "R2 R3 R4 random" : "R1 R3 R4 random", vb, b, w);
      @(negedge clk);
      check("R8 random readback", rd_data, (w & 16'hFFC0) | 16'h0005 | {14'd0, clk_stable, 1'b0});
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule